// File: doc/BRIEF.md
# ADC serial command port

This block is the digital front of a four-channel, 16-bit successive-approximation converter. A host drives a serial slave port made of an active-low select, a serial clock and a data input. The block returns conversion results on a serial output with an enable, and raises a strobe when a result paced by the internal clock is ready. Each command is one byte whose most significant bit is a start marker. The low nibble says whether the byte starts a conversion, sets a channel's input configuration or writes the operating mode. The block holds a per-channel configuration (differential flag and a three-bit range code) and the mode register.

On the core side, a valid conversion command issues a one-cycle request with the channel number and that channel's stored configuration. The converter model answers with a 16-bit offset-binary word and a done pulse. In the external-clock framings a frame is 32 serial clocks, with the result in its last 16. In the internal-clock framing a frame is 24 serial clocks: the strobe marks the moment the host may clock out the 16 result bits. All serial inputs are resynchronised to the system clock, and edges of the serial clock are detected by sampling it.

Top module: `adc_cmd_port`

## Requirements
- R1: After reset, op_mode is 000 (external clock), sdo_en, sstrb and conv_req are low, and every channel's configuration is diff=0, range=001.
- R2: Data-input bits sampled before a 1 (the start marker, byte bit 7) are ignored. The seven bits after the marker complete the byte, MSB first.
- R3: A byte whose bits 3:0 are 0000 is a conversion command for channel bits 6:4. It gives exactly one conv_req pulse, with conv_ch equal to that channel and conv_diff/conv_range equal to its stored configuration.
- R4: A byte whose bits 3:0 are neither 0000 nor 1000 writes bit 3 as the differential flag and bits 2:0 as the range of channel bits 6:4.
- R5: A byte whose bits 3:0 are 1000 is a mode command whose bits 6:4 are the mode code. It never alters a channel configuration. Codes: 000 external clock, 001 external acquisition, 010 internal clock, 100 reset, 110 partial power-down, 111 full power-down.
- R6: Mode codes 011 and 101 leave op_mode unchanged. Channel codes 4 to 7 write no configuration and start no conversion.
- R7: Mode code 100 sets op_mode to 000 and every channel configuration to its reset value.
- R8: While op_mode is 110 or 111, conversion commands produce no conv_req and no output bits.
- R9: In modes 000 and 001, counted from the start-marker clock as clock 1, sdo_en rises at falling edge 16. The result is driven MSB first, one bit per falling edge, so B0 appears at falling edge 31. sdo_en falls at falling edge 32, and sstrb stays low.
- R10: In mode 010, sdo_en stays low until conv_done. On conv_done, sstrb and sdo_en rise with B15 on sdo. The next 15 falling edges give B14..B0, and the 16th drops both sdo_en and sstrb.
- R11: Raising cs_n drops sdo_en and sstrb, abandons the frame and any partly received byte, and the next frame decodes from a fresh start marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command data, sampled on sclk rising edges |
| sdo | output | 1 | Serial result data, updated on sclk falling edges |
| sdo_en | output | 1 | Output driver enable for sdo (low = high impedance) |
| sstrb | output | 1 | Result-ready strobe for the internal-clock mode |
| conv_req | output | 1 | One-cycle conversion request to the converter core |
| conv_ch | output | 2 | Channel for the request |
| conv_diff | output | 1 | Differential flag of the requested channel |
| conv_range | output | 3 | Range code of the requested channel |
| conv_done | input | 1 | Converter result valid pulse |
| conv_data | input | 16 | Converter result, offset binary |
| op_mode | output | 3 | Current mode code for the analog side |

## Verification
The assertions assume that the serial clock is slow compared with the system clock: each sclk level lasts several system cycles beyond the synchroniser delay, so a decode finishes before the next edge. They also assume that the converter answers one request with one done pulse. In the external framings that answer must come before the 16th falling edge. In the internal framing it must come after the 8th falling edge. The bench holds each sclk level for six system cycles and answers each request after thirty cycles, which satisfies both windows. It changes the data input only while sclk is low, and it toggles the select only between bits.

// File: rtl/acp_pkg.sv
package acp_pkg;

   localparam int CMD_BITS = 8;
   localparam int FIELD_W  = 3;

   typedef enum logic [2:0] {
      MD_EXTCLK = 3'b000,
      MD_EXTACQ = 3'b001,
      MD_INTCLK = 3'b010,
      MD_RSV3   = 3'b011,
      MD_RESET  = 3'b100,
      MD_RSV5   = 3'b101,
      MD_PARTPD = 3'b110,
      MD_FULLPD = 3'b111
   } op_mode_e;

   typedef struct packed {
      logic       diff;
      logic [2:0] rng;
   } ch_cfg_t;

   typedef enum logic [1:0] {
      FR_HUNT,
      FR_EXTWAIT,
      FR_INTWAIT,
      FR_SHIFT
   } frame_st_e;

   function automatic logic is_powerdown(input logic [2:0] m);
      return m[2] & m[1];
   endfunction

endpackage

// File: rtl/acp_sync_edge.sv
module acp_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic din,
   output logic cs_act,
   output logic din_s,
   output logic rise,
   output logic fall
);

   logic [2:0] raw;
   logic       sclk_d;

   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad
         $error("acp_sync_edge: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_direct
         assign raw = {cs_n, sclk, din};
      end else begin : g_chain
         logic [2:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= 3'b100;
            end else begin
               pipe[0] <= {cs_n, sclk, din};
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign raw = pipe[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= raw[1];
   end

   assign cs_act = ~raw[2];
   assign din_s  = raw[0];
   assign rise   = raw[1] & ~sclk_d;
   assign fall   = ~raw[1] & sclk_d;

endmodule

// File: rtl/acp_byte_rx.sv
module acp_byte_rx #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         en,
   input  logic         rise,
   input  logic         din,
   output logic         vld,
   output logic [W-1:0] data
);

   localparam int CW = $clog2(W + 1);

   logic [CW-1:0] cnt;
   logic [W-2:0]  sh;

   generate
      if (W < 3) begin : g_bad
         $error("acp_byte_rx: W must be at least 3");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         sh   <= '0;
         vld  <= 1'b0;
         data <= '0;
      end else begin
         vld <= 1'b0;
         if (clear) begin
            cnt <= '0;
         end else if (en && rise) begin
            if (cnt == '0) begin
               if (din) begin
                  sh  <= (W-1)'(1);
                  cnt <= CW'(1);
               end
            end else if (cnt == CW'(W-1)) begin
               data <= {sh, din};
               vld  <= 1'b1;
               cnt  <= '0;
            end else begin
               sh  <= {sh[W-3:0], din};
               cnt <= cnt + CW'(1);
            end
         end
      end
   end

   // R2
   vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld |=> !vld);

   // R11
   clear_novld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !vld);

endmodule

// File: rtl/acp_cmd_regs.sv
module acp_cmd_regs
   import acp_pkg::*;
#(
   parameter int          NUM_CH  = 4,
   parameter logic [3:0]  CFG_RST = 4'b0001
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        vld,
   input  logic [CMD_BITS-1:0]         cmd,
   output op_mode_e                    mode,
   output ch_cfg_t [NUM_CH-1:0]        cfg,
   output logic                        start,
   output logic [FIELD_W-1:0]          start_ch
);

   logic [FIELD_W-1:0] fld;
   logic               is_mode;
   logic               is_conv;
   logic               ch_ok;
   logic               do_reset;

   assign fld      = cmd[6:4];
   assign is_mode  = (cmd[3:0] == 4'b1000);
   assign is_conv  = (cmd[3:0] == 4'b0000);
   assign ch_ok    = ({1'b0, fld} < 4'(NUM_CH));
   assign do_reset = vld && is_mode && (fld == MD_RESET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= MD_EXTCLK;
      end else if (vld && is_mode) begin
         case (op_mode_e'(fld))
            MD_RESET:         mode <= MD_EXTCLK;
            MD_RSV3, MD_RSV5: mode <= mode;
            default:          mode <= op_mode_e'(fld);
         endcase
      end
   end

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cfg[g] <= ch_cfg_t'(CFG_RST);
            end else if (do_reset) begin
               cfg[g] <= ch_cfg_t'(CFG_RST);
            end else if (vld && !is_mode && !is_conv && (fld == FIELD_W'(g))) begin
               cfg[g] <= ch_cfg_t'(cmd[3:0]);
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start    <= 1'b0;
         start_ch <= '0;
      end else begin
         start    <= vld && is_conv && ch_ok && !is_powerdown(mode);
         start_ch <= fld;
      end
   end

   // R6
   mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode inside {MD_RSV3, MD_RSV5, MD_RESET}));

   // R7
   soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_reset |=> (mode == MD_EXTCLK) && (cfg[0] == ch_cfg_t'(CFG_RST)));

   // R5
   mode_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && is_mode && fld != MD_RESET) |=> $stable(cfg));

endmodule

// File: rtl/acp_word_tx.sv
module acp_word_tx #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         load,
   input  logic [W-1:0] data,
   input  logic         fall,
   output logic         oe,
   output logic         bit_o,
   output logic         fin
);

   localparam int CW = $clog2(W);

   logic [W-1:0]  sh;
   logic [CW-1:0] cnt;

   generate
      if (W < 2) begin : g_bad
         $error("acp_word_tx: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
         oe  <= 1'b0;
         fin <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (clear) begin
            oe  <= 1'b0;
            cnt <= '0;
         end else if (load) begin
            sh  <= data;
            oe  <= 1'b1;
            cnt <= '0;
         end else if (oe && fall) begin
            if (cnt == CW'(W-1)) begin
               oe  <= 1'b0;
               fin <= 1'b1;
            end else begin
               sh  <= {sh[W-2:0], 1'b0};
               cnt <= cnt + CW'(1);
            end
         end
      end
   end

   assign bit_o = sh[W-1];

   // R9
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && !fall && !load && !clear) |=> (oe && $stable(bit_o)));

endmodule

// File: rtl/adc_cmd_port.sv
module adc_cmd_port
   import acp_pkg::*;
#(
   parameter int         NUM_CH      = 4,
   parameter int         DATA_W      = 16,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] CFG_RST     = 4'b0001
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cs_n,
   input  logic                      sclk,
   input  logic                      din,
   output logic                      sdo,
   output logic                      sdo_en,
   output logic                      sstrb,
   output logic                      conv_req,
   output logic [$clog2(NUM_CH)-1:0] conv_ch,
   output logic                      conv_diff,
   output logic [2:0]                conv_range,
   input  logic                      conv_done,
   input  logic [DATA_W-1:0]         conv_data,
   output logic [2:0]                op_mode
);

   localparam int CH_W       = $clog2(NUM_CH);
   localparam int LEAD_FALLS = CMD_BITS;
   localparam int FC_W       = $clog2(LEAD_FALLS + 1);

   generate
      if (NUM_CH < 2 || NUM_CH > 8) begin : g_bad_ch
         $error("adc_cmd_port: NUM_CH must be 2..8");
      end
      if (DATA_W < 2) begin : g_bad_w
         $error("adc_cmd_port: DATA_W must be at least 2");
      end
   endgenerate

   logic                  cs_act, din_s, rise, fall;
   logic                  rx_vld;
   logic [CMD_BITS-1:0]   rx_byte;
   op_mode_e              mode;
   ch_cfg_t [NUM_CH-1:0]  cfg;
   logic                  start;
   logic [FIELD_W-1:0]    start_ch;
   frame_st_e             st;
   logic [FC_W-1:0]       fcnt;
   logic                  int_q;
   logic [DATA_W-1:0]     res_q;
   logic                  tx_load, tx_oe, tx_bit, tx_fin;
   logic [DATA_W-1:0]     tx_data;

   acp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .cs_act(cs_act), .din_s(din_s), .rise(rise), .fall(fall)
   );

   acp_byte_rx #(.W(CMD_BITS)) u_rx (
      .clk(clk), .rst_n(rst_n), .clear(!cs_act), .en(st == FR_HUNT),
      .rise(rise), .din(din_s), .vld(rx_vld), .data(rx_byte)
   );

   acp_cmd_regs #(.NUM_CH(NUM_CH), .CFG_RST(CFG_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .vld(rx_vld), .cmd(rx_byte),
      .mode(mode), .cfg(cfg), .start(start), .start_ch(start_ch)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= FR_HUNT;
         fcnt  <= '0;
         int_q <= 1'b0;
         res_q <= '0;
      end else if (!cs_act) begin
         st <= FR_HUNT;
      end else begin
         case (st)
            FR_HUNT: begin
               if (start) begin
                  st    <= (mode == MD_INTCLK) ? FR_INTWAIT : FR_EXTWAIT;
                  int_q <= (mode == MD_INTCLK);
                  fcnt  <= '0;
               end
            end
            FR_EXTWAIT: begin
               if (conv_done) res_q <= conv_data;
               if (fall) begin
                  if (fcnt == FC_W'(LEAD_FALLS)) st <= FR_SHIFT;
                  else                           fcnt <= fcnt + FC_W'(1);
               end
            end
            FR_INTWAIT: begin
               if (conv_done) st <= FR_SHIFT;
            end
            FR_SHIFT: begin
               if (tx_fin) st <= FR_HUNT;
            end
            default: st <= FR_HUNT;
         endcase
      end
   end

   assign tx_load = cs_act &&
                    (((st == FR_EXTWAIT) && fall && (fcnt == FC_W'(LEAD_FALLS))) ||
                     ((st == FR_INTWAIT) && conv_done));
   assign tx_data = (st == FR_INTWAIT) ? conv_data : res_q;

   acp_word_tx #(.W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .clear(!cs_act), .load(tx_load),
      .data(tx_data), .fall(fall), .oe(tx_oe), .bit_o(tx_bit), .fin(tx_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_req   <= 1'b0;
         conv_ch    <= '0;
         conv_diff  <= 1'b0;
         conv_range <= '0;
      end else begin
         conv_req <= start && cs_act;
         if (start) begin
            conv_ch    <= start_ch[CH_W-1:0];
            conv_diff  <= cfg[start_ch[CH_W-1:0]].diff;
            conv_range <= cfg[start_ch[CH_W-1:0]].rng;
         end
      end
   end

   assign sdo     = tx_bit;
   assign sdo_en  = tx_oe;
   assign sstrb   = tx_oe & int_q;
   assign op_mode = mode;

   // R11
   cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (!sdo_en && !sstrb));

   // R8
   pd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> !(op_mode[2] && op_mode[1]));

   // R3
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |=> !conv_req);

   // R10
   strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sstrb) |-> $past(conv_done));

endmodule

// File: tb/tb_adc_cmd_port.sv
module tb_adc_cmd_port;

   localparam int H   = 6;
   localparam int LAT = 30;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n, cs_n, sclk, din;
   logic        sdo, sdo_en, sstrb, conv_req, conv_diff, conv_done;
   logic [1:0]  conv_ch;
   logic [2:0]  conv_range, op_mode;
   logic [15:0] conv_data;

   adc_cmd_port dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .sdo(sdo), .sdo_en(sdo_en), .sstrb(sstrb),
      .conv_req(conv_req), .conv_ch(conv_ch), .conv_diff(conv_diff),
      .conv_range(conv_range), .conv_done(conv_done), .conv_data(conv_data),
      .op_mode(op_mode)
   );

   int total = 0;
   int bad   = 0;

   int         nreq = 0;
   logic [1:0] last_ch;
   logic       last_diff;
   logic [2:0] last_rng;
   logic [3:0] ecfg [4];

   function automatic logic [15:0] mword(input logic [1:0] ch, input int n);
      return 16'h4D2B ^ 16'(n * 3851) ^ {4{2'b00, ch}};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // converter core model
   initial begin
      logic [15:0] cur;
      conv_done = 1'b0;
      conv_data = '0;
      forever begin
         @(negedge clk);
         if (conv_req) begin
            nreq++;
            last_ch   = conv_ch;
            last_diff = conv_diff;
            last_rng  = conv_range;
            cur = mword(conv_ch, nreq);
            repeat (LAT) @(negedge clk);
            conv_data = cur;
            conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sbit(input logic d, output logic so, output logic soe, output logic st);
      @(negedge clk);
      din = d;
      idle(H);
      so = sdo; soe = sdo_en; st = sstrb;
      sclk = 1'b1;
      idle(H);
      sclk = 1'b0;
   endtask

   task automatic sbyte(input logic [7:0] b);
      logic a, e, s;
      for (int i = 7; i >= 0; i--) sbit(b[i], a, e, s);
   endtask

   task automatic fbegin();
      @(negedge clk);
      cs_n = 1'b0;
      idle(4);
   endtask

   task automatic fend();
      @(negedge clk);
      cs_n = 1'b1;
      din  = 1'b0;
      idle(8);
   endtask

   task automatic cfg_write(input logic [2:0] ch, input logic dif, input logic [2:0] rng);
      fbegin();
      sbyte({1'b1, ch, dif, rng});
      fend();
   endtask

   task automatic mode_write(input logic [2:0] m);
      fbegin();
      sbyte({1'b1, m, 4'b1000});
      fend();
   endtask

   // external framing: 32 clocks after 'pre' leading zeros
   task automatic ext_conv(input logic [1:0] ch, input int pre, input string req);
      logic [7:0]  cmd;
      logic [15:0] w, exp;
      logic        so, soe, st, en_ok, st_seen, b;
      int          n0;
      cmd = {1'b1, 1'b0, ch, 4'b0000};
      n0 = nreq;
      exp = mword(ch, nreq + 1);
      en_ok = 1'b1; st_seen = 1'b0; w = '0;
      fbegin();
      for (int p = 1; p <= pre + 32; p++) begin
         if (p > pre && p <= pre + 8) b = cmd[7 - (p - pre - 1)];
         else                         b = 1'b0;
         sbit(b, so, soe, st);
         if (soe !== (p > pre + 16)) en_ok = 1'b0;
         if (st) st_seen = 1'b1;
         if (p > pre + 16) w[15 - (p - pre - 17)] = so;
      end
      idle(H);
      chk(req, "enable window", {31'b0, en_ok}, 32'd1);
      chk(req, "result word", {16'b0, w}, {16'b0, exp});
      chk(req, "strobe low in external framing", {31'b0, st_seen}, 32'd0);
      chk(req, "released after frame", {31'b0, sdo_en}, 32'd0);
      chk("R3", "one request", nreq - n0, 32'd1);
      chk("R3", "channel", {30'b0, last_ch}, {30'b0, ch});
      fend();
   endtask

   task automatic ext_noconv(input logic [2:0] ch, input string req);
      logic so, soe, st, any;
      int   n0;
      n0 = nreq; any = 1'b0;
      fbegin();
      sbyte({1'b1, ch, 4'b0000});
      for (int p = 9; p <= 32; p++) begin
         sbit(1'b0, so, soe, st);
         if (soe || st) any = 1'b1;
      end
      idle(LAT);
      chk(req, "no request", nreq - n0, 32'd0);
      chk(req, "no output bits", {31'b0, any}, 32'd0);
      fend();
   endtask

   task automatic int_conv(input logic [1:0] ch, input string req);
      logic [15:0] w, exp;
      logic        so, soe, st, ok;
      int          waitc;
      exp = mword(ch, nreq + 1);
      fbegin();
      sbyte({1'b1, 1'b0, ch, 4'b0000});
      chk(req, "no drive before done", {31'b0, sdo_en}, 32'd0);
      waitc = 0;
      while (!sstrb && waitc < 200) begin
         @(negedge clk);
         waitc++;
      end
      chk(req, "strobe rises", {31'b0, sstrb}, 32'd1);
      ok = 1'b1; w = '0;
      for (int p = 9; p <= 24; p++) begin
         sbit(1'b0, so, soe, st);
         if (!soe || !st) ok = 1'b0;
         w[15 - (p - 9)] = so;
      end
      idle(H);
      chk(req, "enable and strobe during read", {31'b0, ok}, 32'd1);
      chk(req, "result word", {16'b0, w}, {16'b0, exp});
      chk(req, "released after 16 falls", {30'b0, sdo_en, sstrb}, 32'd0);
      fend();
   endtask

   task automatic conv_cfg_chk(input logic [1:0] ch, input string req);
      ext_conv(ch, 0, req);
      chk(req, "config on request", {28'b0, last_diff, last_rng}, {28'b0, ecfg[ch]});
   endtask

   initial begin
      logic so, soe, st;
      cs_n = 1'b1; sclk = 1'b0; din = 1'b0; rst_n = 1'b0;
      for (int i = 0; i < 4; i++) ecfg[i] = 4'b0001;
      idle(5);
      rst_n = 1'b1;
      idle(5);

      // R1 reset state
      chk("R1", "op_mode", {29'b0, op_mode}, 32'd0);
      chk("R1", "outputs idle", {29'b0, sdo_en, sstrb, conv_req}, 32'd0);
      for (int c = 0; c < 4; c++) conv_cfg_chk(2'(c), "R1");

      // R9 external framing over all channels, R2 with leading zeros
      for (int c = 0; c < 4; c++) ext_conv(2'(c), 0, "R9");
      ext_conv(2'd1, 3, "R2");
      ext_conv(2'd3, 7, "R2");

      // R4 configuration sweep (00000 and 1000 low nibbles are other commands)
      for (int c = 0; c < 4; c++)
         for (int d = 0; d < 2; d++)
            for (int r = 1; r < 8; r++) begin
               cfg_write(3'(c), 1'(d), 3'(r));
               ecfg[c] = {1'(d), 3'(r)};
               conv_cfg_chk(2'(c), "R4");
            end

      // R6 channel codes 4..7 ignored
      for (int c = 4; c < 8; c++) cfg_write(3'(c), 1'b1, 3'b110);
      for (int c = 0; c < 4; c++) conv_cfg_chk(2'(c), "R6");
      for (int c = 4; c < 8; c++) ext_noconv(3'(c), "R6");

      // R5 mode byte 1_001_1000 is a mode write, not a config of channel 1
      mode_write(3'b001);
      chk("R5", "op_mode external acquisition", {29'b0, op_mode}, 32'd1);
      conv_cfg_chk(2'd1, "R5");

      // R10 internal clock framing
      mode_write(3'b010);
      chk("R5", "op_mode internal", {29'b0, op_mode}, 32'd2);
      for (int c = 0; c < 4; c++) int_conv(2'(c), "R10");

      // R6 reserved codes
      mode_write(3'b011);
      chk("R6", "reserved 011 ignored", {29'b0, op_mode}, 32'd2);
      mode_write(3'b101);
      chk("R6", "reserved 101 ignored", {29'b0, op_mode}, 32'd2);

      // R8 power-down drops conversions
      mode_write(3'b110);
      chk("R8", "op_mode partial", {29'b0, op_mode}, 32'd6);
      ext_noconv(3'd0, "R8");
      mode_write(3'b111);
      chk("R8", "op_mode full", {29'b0, op_mode}, 32'd7);
      ext_noconv(3'd3, "R8");
      mode_write(3'b000);
      ext_conv(2'd2, 0, "R8");

      // R7 reset command
      cfg_write(3'd2, 1'b1, 3'b101);
      mode_write(3'b010);
      mode_write(3'b100);
      chk("R7", "op_mode after reset code", {29'b0, op_mode}, 32'd0);
      for (int i = 0; i < 4; i++) ecfg[i] = 4'b0001;
      conv_cfg_chk(2'd2, "R7");
      conv_cfg_chk(2'd0, "R7");

      // R11 abort mid read-out
      fbegin();
      sbyte({1'b1, 3'd1, 4'b0000});
      for (int p = 9; p <= 20; p++) sbit(1'b0, so, soe, st);
      chk("R11", "driving before abort", {31'b0, sdo_en}, 32'd1);
      @(negedge clk);
      cs_n = 1'b1;
      idle(6);
      chk("R11", "released on select high", {30'b0, sdo_en, sstrb}, 32'd0);
      idle(LAT);
      // R11 partial byte discarded
      fbegin();
      sbit(1'b1, so, soe, st);
      sbit(1'b0, so, soe, st);
      sbit(1'b1, so, soe, st);
      sbit(1'b1, so, soe, st);
      fend();
      ext_conv(2'd2, 0, "R11");
      conv_cfg_chk(2'd3, "R11");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule